// File: doc/BRIEF.md
# Time-Interleaved Oscillator Edge-Count Quantizer

This block is the digital back end of an oscillator-based analog-to-digital converter. The square-wave phase outputs of a voltage-controlled oscillator arrive as asynchronous levels. Each one is brought into the sample-clock domain and watched for transitions. Depending on a mode input, a transition counts if it is rising only, or if it is either rising or falling. The number of counted transitions over a window measures the oscillator's phase advance, so it is proportional to the analog input.

The block has N interleaved channels. Each channel owns a saturating accumulator whose window is N sample-clock cycles long. Channel k closes its window and restarts at cycle slot k, so successive channels are offset by one sample period. A round-robin selector takes the closing channel's total every cycle. It passes that total through an optional code table and registers the result, which gives one output sample per sample clock. Because the overlapping windows are merged in turn, the quantization noise is shaped as 1 - z^-N. The output is marked invalid until only complete windows are being delivered.

Top module: `vco_tiq`

## Requirements
- R1: While reset is asserted, out_valid is 0, out_code is 0 and out_chan is 0.
- R2: With both_edges = 0, only 0-to-1 transitions of a phase input add to a count. A 1-to-0 transition adds nothing.
- R3: With both_edges = 1, every transition of a phase input in either direction adds one to a count.
- R4: Transitions on all PHASES inputs within the same cycle are summed into the count.
- R5: Each input passes through two synchronizer stages. A transition applied before clock edge e is credited at edge e+2. The sample registered at edge j is the total credited over edges j-N+1 through j, where N = CHANNELS.
- R6: out_chan follows 0, 1, ..., N-1 and then repeats, starting with 0 at the first clock edge after reset. The sample registered at edge j comes from channel (j-1) mod N.
- R7: A window total never wraps. It saturates at 2^CNT_W - 1.
- R8: out_valid is 0 for the first N samples after reset. It rises with channel 0's sample at edge N+1, which is its first complete window, and stays 1 after that.
- R9: With USE_LUT = 0, out_code is the window total zero-extended to OUT_W bits. With USE_LUT = 1, out_code is the OUT_W-bit entry at bit offset total*OUT_W of CODE_TABLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock fs |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_ph | input | PHASES | Asynchronous oscillator phase levels |
| both_edges | input | 1 | 1: count both polarities, 0: rising only |
| out_code | output | OUT_W | Mapped window count |
| out_chan | output | $clog2(CHANNELS) | Channel that produced out_code |
| out_valid | output | 1 | Sample holds a complete window |

## Verification
The assertions check on every cycle the following structural properties:
- the round-robin channel order;
- that valid never falls once it has risen;
- that each accumulator clears in the cycle after its own slot;
- that a saturated accumulator holds its value.

The numeric content of each sample can only be shown by the bench's scenarios. The bench models the two-stage synchronizer latency, the N-cycle window sum, the polarity mode, multi-phase summation and the saturation limit, then compares the identity instance and the table-mapped instance against that model.

// File: rtl/vco_tiq.sv
module vco_tiq #(
  parameter int CHANNELS = 4,
  parameter int PHASES = 2,
  parameter int CNT_W = 3,
  parameter int OUT_W = 4,
  parameter bit USE_LUT = 1'b0,
  parameter logic [OUT_W*(2**CNT_W)-1:0] CODE_TABLE = '0,
  localparam int CH_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] vco_ph,
  input  logic              both_edges,
  output logic [OUT_W-1:0]  out_code,
  output logic [CH_W-1:0]   out_chan,
  output logic              out_valid
);
  localparam int INC_W = $clog2(PHASES + 1);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic [PHASES-1:0] sy1, sy2, sy3;
  logic [PHASES-1:0] hit;
  logic [INC_W-1:0] inc;
  logic [CH_W-1:0] slot;
  logic primed;
  logic [CHANNELS-1:0][CNT_W-1:0] acc;
  logic [CHANNELS-1:0][CNT_W-1:0] nxt;
  logic [CNT_W-1:0] sel;
  logic [OUT_W-1:0] mapped;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= vco_ph;
      sy2 <= sy1;
      sy3 <= sy2;
    end

  assign hit = (sy2 & ~sy3) | ({PHASES{both_edges}} & ~sy2 & sy3);
  assign inc = INC_W'($countones(hit));

  for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
    logic [CNT_W:0] sum;
    assign sum = {1'b0, acc[k]} + (CNT_W+1)'(inc);
    assign nxt[k] = sum[CNT_W] ? MAXC : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc <= '0;
      slot <= '0;
      primed <= 1'b0;
    end else begin
      for (int k = 0; k < CHANNELS; k++)
        acc[k] <= (slot == CH_W'(k)) ? '0 : nxt[k];
      slot <= (slot == CH_W'(CHANNELS-1)) ? '0 : slot + 1'b1;
      if (slot == CH_W'(CHANNELS-1)) primed <= 1'b1;
    end

  assign sel = nxt[slot];

  if (USE_LUT) begin : g_lut
    assign mapped = CODE_TABLE[int'(sel)*OUT_W +: OUT_W];
  end else begin : g_ident
    assign mapped = OUT_W'(sel);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_code <= '0;
      out_chan <= '0;
      out_valid <= 1'b0;
    end else begin
      out_code <= mapped;
      out_chan <= slot;
      out_valid <= primed;
    end
endmodule

// File: rtl/vco_tiq_chk.sv
module vco_tiq_chk #(
  parameter int CHANNELS = 4,
  parameter int CNT_W = 3,
  parameter int CH_W = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [CH_W-1:0]                slot,
  input logic [CHANNELS-1:0][CNT_W-1:0] acc,
  input logic [CH_W-1:0]                out_chan,
  input logic                           out_valid
);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  p_rr_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_chan == CH_W'((int'($past(out_chan)) + 1) % CHANNELS));

  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  for (genvar k = 0; k < CHANNELS; k++) begin : g_k
    p_window_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == CH_W'(k)) |=> acc[k] == '0);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot != CH_W'(k) && acc[k] == MAXC) |=> acc[k] == MAXC);
  end
endmodule

bind vco_tiq vco_tiq_chk #(.CHANNELS(CHANNELS), .CNT_W(CNT_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot(slot), .acc(acc),
  .out_chan(out_chan), .out_valid(out_valid));

// File: tb/vco_tiq_test.sv
`timescale 1ns/1ps
module vco_tiq_test;
  localparam int N = 4;
  localparam int P = 2;
  localparam int W = 3;
  localparam int OW = 4;
  localparam int MAXC = (1 << W) - 1;

  function automatic logic [OW*(2**W)-1:0] build_tab();
    logic [OW*(2**W)-1:0] t;
    for (int i = 0; i < 2**W; i++) t[i*OW +: OW] = OW'(15 - i);
    return t;
  endfunction

  logic clk = 0, rst_n = 0, both = 0;
  logic [P-1:0] ph = '0;
  logic [OW-1:0] code_a, code_b;
  logic [1:0] chan_a, chan_b;
  logic val_a, val_b;

  vco_tiq #(.CHANNELS(N), .PHASES(P), .CNT_W(W), .OUT_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .vco_ph(ph), .both_edges(both),
    .out_code(code_a), .out_chan(chan_a), .out_valid(val_a));

  vco_tiq #(.CHANNELS(N), .PHASES(P), .CNT_W(W), .OUT_W(OW), .USE_LUT(1'b1),
            .CODE_TABLE(build_tab())) uut_lut (
    .clk(clk), .rst_n(rst_n), .vco_ph(ph), .both_edges(both),
    .out_code(code_b), .out_chan(chan_b), .out_valid(val_b));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, ecount = 0;
  int ev [0:255];
  string tag = "R5";
  bit done = 0;

  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d edge=%0d", req, act, exp, ecount);
    end
  endtask

  function automatic int exp_sum(input int j);
    int s = 0;
    for (int i = j - N - 1; i <= j - 2; i++) if (i >= 1) s += ev[i % 256];
    return (s > MAXC) ? MAXC : s;
  endfunction

  task automatic check_now();
    int j = ecount;
    int e = exp_sum(j);
    chk(code_a == OW'(e), tag, code_a, e);
    chk(code_b == OW'(15 - e), "R9", code_b, 15 - e);
    chk(chan_a == 2'((j - 1) % N), "R6", chan_a, (j - 1) % N);
    chk(val_a == (j >= N + 1), "R8", val_a, j >= N + 1);
  endtask

  task automatic drive(input logic [P-1:0] mask, input bit dense);
    logic [P-1:0] nw, tg;
    int c = 0;
    tg = dense ? mask : (P'($urandom) & mask);
    nw = ph ^ tg;
    for (int p = 0; p < P; p++) begin
      if (!ph[p] && nw[p]) c++;
      if (ph[p] && !nw[p] && both) c++;
    end
    ev[(ecount + 1) % 256] = c;
    ph = nw;
  endtask

  task automatic run(input int n, input logic [P-1:0] mask, input bit dense);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
      drive(mask, dense);
    end
  endtask

  task automatic set_mode(input bit m, input string t);
    run(4, '0, 0);
    both = m;
    tag = t;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) ev[i] = 0;
    repeat (3) @(negedge clk);
    chk(val_a == 0 && code_a == 0 && chan_a == 0, "R1", {val_a, code_a, chan_a}, 0);
    rst_n = 1;
    set_mode(0, "R2"); run(40, 2'b01, 0); run(20, 2'b01, 1);
    set_mode(1, "R3"); run(40, 2'b01, 0);
    set_mode(1, "R4"); run(40, 2'b11, 0);
    set_mode(0, "R4"); run(20, 2'b11, 1);
    set_mode(1, "R7"); run(30, 2'b11, 1);
    set_mode(0, "R5");
    for (int s = 0; s < 20; s++) begin
      set_mode(s[0], "R5");
      run(100, 2'b11, 0);
    end
    run(8, '0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors + 0);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule